// File: doc/BRIEF.md
# Pretriggered Analog Reference Trigger

This block watches the sample stream of one channel, picked from a multi-channel bus, and decides when a finite capture has reached its reference point. A capture begins with a start pulse. The block then collects a programmed number of pretrigger samples. Until that count is met, a matching signal condition is not acted on. Once armed, the first sample that meets the selected condition becomes the reference sample. The block emits a one-cycle strobe and records that sample's position in the capture. It then counts a programmed number of later samples and raises a done flag for the capture buffer.

Three condition families are supported: a plain level crossing with a slope select, a level crossing gated by a hysteresis band, and a window test that fires either inside or outside two limits. The trigger instant is the sample that met the condition, so timing resolution is one sample period. The block serves reference captures only. A request to use it as a start trigger is refused and flagged.

Top module: `rtrig_unit`

## Requirements
- R1: After reset, `trig_pulse`, `armed`, `done` and `cfg_err` are all low.
- R2: After an accepted start, `armed` goes high one cycle after the valid sample whose zero-based index equals `cfg_pre`-1, or one cycle after the start when `cfg_pre` is 0. No sample with index below `cfg_pre` can trigger.
- R3: With `cfg_mode`=0 (crossing), the condition holds on a sample when the previous sample of the same capture is below `cfg_level` and the current one is at or above it (`cfg_slope`=0, rising). With `cfg_slope`=1 (falling), it holds when the previous sample is above the level and the current one is at or below it. The first sample of a capture never meets this condition.
- R4: With `cfg_mode`=1 (hysteresis), rising: a sample below `cfg_level`-`cfg_hyst` primes the condition, and the first later sample at or above `cfg_level` meets it and unprimes it. Falling mirrors this with `cfg_level`+`cfg_hyst` and "at or below". A crossing without priming does not fire.
- R5: With `cfg_mode`=2, a sample meets the condition when `cfg_level` <= x <= `cfg_level_hi`. With `cfg_mode`=3, it meets the condition when x < `cfg_level` or x > `cfg_level_hi`. Both limits are inclusive to the inside.
- R6: While armed, the first valid sample that meets the condition makes `trig_pulse` high for exactly the next cycle. In that same cycle, `trig_idx` shows the sample's zero-based index within the capture.
- R7: At most one trigger occurs per capture. `armed` is low from the trigger strobe onward.
- R8: `done` rises one cycle after the `cfg_post`-th valid sample that follows the trigger sample, or together with `trig_pulse` when `cfg_post` is 0. It holds until the next accepted start.
- R9: A start with `cfg_as_start`=1 is refused: `cfg_err` goes high the next cycle and the capture state is left unchanged. An accepted start clears `cfg_err`.
- R10: Only the lane of `smp_bus` at bit offset `chan_sel`*W is evaluated. Activity on other lanes has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A new sample is present on all lanes |
| smp_bus | input | NCH*W | Signed samples, lane i at bits i*W +: W |
| chan_sel | input | SEL_W | Lane to monitor |
| cfg_mode | input | 2 | 0 crossing, 1 hysteresis, 2 inside window, 3 outside window |
| cfg_slope | input | 1 | 0 rising, 1 falling |
| cfg_level | input | W | Signed trigger level / lower window limit |
| cfg_level_hi | input | W | Signed upper window limit |
| cfg_hyst | input | W | Unsigned hysteresis amount |
| cfg_pre | input | CW | Pretrigger sample count |
| cfg_post | input | CW | Posttrigger sample count |
| cfg_as_start | input | 1 | Request to use the trigger as a start trigger (refused) |
| start | input | 1 | Begin a capture |
| trig_pulse | output | 1 | One-cycle trigger strobe |
| trig_idx | output | IDX_W | Index of the trigger sample |
| armed | output | 1 | Pretrigger met, waiting for condition |
| done | output | 1 | Posttrigger count complete |
| cfg_err | output | 1 | Refused start-trigger request |

## Verification
The bench builds the block with four 12-bit lanes, 8-bit sample counts and a 12-bit index. This keeps level, hysteresis and window values small and exact, with both signs. It lets captures with pretrigger and posttrigger counts of zero, one and several complete in a few dozen cycles. Those sizes reach the boundary samples directly: a crossing inside the pretrigger region, a trigger on sample zero, a sample exactly at a limit, a posttrigger count of zero, and a crossing placed only on an unselected lane.

// File: rtl/rtrig_pkg.sv
package rtrig_pkg;
  typedef enum logic [1:0] {
    TM_CROSS   = 2'd0,
    TM_HYST    = 2'd1,
    TM_WIN_IN  = 2'd2,
    TM_WIN_OUT = 2'd3
  } trig_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_PRE   = 3'd1,
    SQ_ARMED = 3'd2,
    SQ_POST  = 3'd3,
    SQ_DONE  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/rtrig_lane_mux.sv
module rtrig_lane_mux #(
  parameter int NCH = 4,
  parameter int W   = 12,
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH*W-1:0] bus,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     lane_out
);
  logic [W-1:0] lane [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign lane[g] = bus[g*W +: W];
  end

  always_comb begin
    lane_out = '0;
    for (int i = 0; i < NCH; i++) begin
      if (sel == SEL_W'(i)) lane_out = lane[i];
    end
  end
endmodule

// File: rtl/rtrig_cond.sv
module rtrig_cond
  import rtrig_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                smp_en,
  input  logic signed [W-1:0] smp,
  input  trig_mode_e          mode,
  input  logic                slope,
  input  logic signed [W-1:0] lvl,
  input  logic signed [W-1:0] lvl_hi,
  input  logic        [W-1:0] hyst,
  output logic                hit
);
  localparam int EW = W + 2;

  logic signed [W-1:0]  prev_q, prev_n;
  logic                 has_prev_q, has_prev_n;
  logic                 primed_q, primed_n;

  logic signed [EW-1:0] x_e, p_e, lo_e, hi_e, hy_e, thr_dn, thr_up;
  logic                 x_ge, x_le, edge_hit, hyst_hit, in_win;

  always_comb begin
    x_e    = $signed({{2{smp[W-1]}}, smp});
    p_e    = $signed({{2{prev_q[W-1]}}, prev_q});
    lo_e   = $signed({{2{lvl[W-1]}}, lvl});
    hi_e   = $signed({{2{lvl_hi[W-1]}}, lvl_hi});
    hy_e   = $signed({2'b00, hyst});
    thr_dn = lo_e - hy_e;
    thr_up = lo_e + hy_e;
    x_ge   = (x_e >= lo_e);
    x_le   = (x_e <= lo_e);
    in_win = x_ge && (x_e <= hi_e);

    if (slope) edge_hit = has_prev_q && (p_e > lo_e) && x_le;
    else       edge_hit = has_prev_q && (p_e < lo_e) && x_ge;

    hyst_hit = primed_q && (slope ? x_le : x_ge);

    unique case (mode)
      TM_CROSS:   hit = edge_hit;
      TM_HYST:    hit = hyst_hit;
      TM_WIN_IN:  hit = in_win;
      TM_WIN_OUT: hit = !in_win;
      default:    hit = 1'b0;
    endcase
  end

  always_comb begin
    prev_n     = prev_q;
    has_prev_n = has_prev_q;
    primed_n   = primed_q;
    if (clr) begin
      prev_n     = '0;
      has_prev_n = 1'b0;
      primed_n   = 1'b0;
    end else if (smp_en) begin
      prev_n     = smp;
      has_prev_n = 1'b1;
      if (!slope) begin
        if (x_e < thr_dn) primed_n = 1'b1;
        else if (x_ge)    primed_n = 1'b0;
      end else begin
        if (x_e > thr_up) primed_n = 1'b1;
        else if (x_le)    primed_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= '0;
      has_prev_q <= 1'b0;
      primed_q   <= 1'b0;
    end else if (clr || smp_en) begin
      prev_q     <= prev_n;
      has_prev_q <= has_prev_n;
      primed_q   <= primed_n;
    end
  end
endmodule

// File: rtl/rtrig_seq.sv
module rtrig_seq
  import rtrig_pkg::*;
#(
  parameter int CW    = 8,
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             as_start,
  input  logic             smp_valid,
  input  logic             hit,
  input  logic [CW-1:0]    pre_cnt,
  input  logic [CW-1:0]    post_cnt,
  output logic             active,
  output logic             clr_hist,
  output logic             trig_pulse,
  output logic [IDX_W-1:0] trig_idx,
  output logic             armed,
  output logic             done,
  output logic             cfg_err
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  seq_state_e       st_q, st_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [CW:0]      post_q, post_n;
  logic             tp_q, tp_n;
  logic [IDX_W-1:0] tidx_q, tidx_n;
  logic             err_q, err_n;
  logic             smp_en;
  logic [IDX_W-1:0] pre_ext;

  assign active   = (st_q == SQ_PRE) || (st_q == SQ_ARMED) || (st_q == SQ_POST);
  assign clr_hist = start && !as_start;
  assign smp_en   = smp_valid && !start && active;
  assign pre_ext  = IDX_W'(pre_cnt);

  always_comb begin
    st_n   = st_q;
    idx_n  = idx_q;
    post_n = post_q;
    tp_n   = 1'b0;
    tidx_n = tidx_q;
    err_n  = err_q;
    if (start) begin
      if (as_start) begin
        err_n = 1'b1;
      end else begin
        err_n  = 1'b0;
        st_n   = (pre_cnt == '0) ? SQ_ARMED : SQ_PRE;
        idx_n  = '0;
        post_n = '0;
      end
    end else if (smp_en) begin
      unique case (st_q)
        SQ_PRE: begin
          if (idx_q + 1'b1 == pre_ext) st_n = SQ_ARMED;
        end
        SQ_ARMED: begin
          if (hit) begin
            tp_n   = 1'b1;
            tidx_n = idx_q;
            st_n   = (post_cnt == '0) ? SQ_DONE : SQ_POST;
          end
        end
        SQ_POST: begin
          post_n = post_q + 1'b1;
          if (post_q + 1'b1 == {1'b0, post_cnt}) st_n = SQ_DONE;
        end
        default: st_n = st_q;
      endcase
      if (idx_q != IDX_MAX) idx_n = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      idx_q  <= '0;
      post_q <= '0;
      tp_q   <= 1'b0;
      tidx_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      idx_q  <= idx_n;
      post_q <= post_n;
      tp_q   <= tp_n;
      tidx_q <= tidx_n;
      err_q  <= err_n;
    end
  end

  assign trig_pulse = tp_q;
  assign trig_idx   = tidx_q;
  assign armed      = (st_q == SQ_ARMED);
  assign done       = (st_q == SQ_DONE);
  assign cfg_err    = err_q;
endmodule

// File: rtl/rtrig_unit.sv
module rtrig_unit
  import rtrig_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int W     = 12,
  parameter int CW    = 8,
  parameter int IDX_W = 12,
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [NCH*W-1:0] smp_bus,
  input  logic [SEL_W-1:0] chan_sel,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_slope,
  input  logic [W-1:0]     cfg_level,
  input  logic [W-1:0]     cfg_level_hi,
  input  logic [W-1:0]     cfg_hyst,
  input  logic [CW-1:0]    cfg_pre,
  input  logic [CW-1:0]    cfg_post,
  input  logic             cfg_as_start,
  input  logic             start,
  output logic             trig_pulse,
  output logic [IDX_W-1:0] trig_idx,
  output logic             armed,
  output logic             done,
  output logic             cfg_err
);
  logic [W-1:0] lane_x;
  logic         hit, active, clr_hist, cond_en;
  trig_mode_e   mode;

  assign mode    = trig_mode_e'(cfg_mode);
  assign cond_en = smp_valid && !start && active;

  rtrig_lane_mux #(.NCH(NCH), .W(W)) u_mux (
    .bus      (smp_bus),
    .sel      (chan_sel),
    .lane_out (lane_x)
  );

  rtrig_cond #(.W(W)) u_cond (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_hist),
    .smp_en (cond_en),
    .smp    ($signed(lane_x)),
    .mode   (mode),
    .slope  (cfg_slope),
    .lvl    ($signed(cfg_level)),
    .lvl_hi ($signed(cfg_level_hi)),
    .hyst   (cfg_hyst),
    .hit    (hit)
  );

  rtrig_seq #(.CW(CW), .IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .as_start   (cfg_as_start),
    .smp_valid  (smp_valid),
    .hit        (hit),
    .pre_cnt    (cfg_pre),
    .post_cnt   (cfg_post),
    .active     (active),
    .clr_hist   (clr_hist),
    .trig_pulse (trig_pulse),
    .trig_idx   (trig_idx),
    .armed      (armed),
    .done       (done),
    .cfg_err    (cfg_err)
  );
endmodule

// File: rtl/rtrig_unit_chk.sv
module rtrig_unit_chk #(
  parameter int CW    = 8,
  parameter int IDX_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             cfg_as_start,
  input logic [CW-1:0]    cfg_pre,
  input logic             trig_pulse,
  input logic [IDX_W-1:0] trig_idx,
  input logic             armed,
  input logic             done,
  input logic             cfg_err
);
  // R6: a strobe only follows a cycle spent armed
  a_r6_pulse_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> $past(armed));

  // R7: strobe lasts one cycle and leaves the block disarmed
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);
  a_r7_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> !armed);

  // R2: reference sample never lies inside the pretrigger region
  a_r2_idx_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> (trig_idx >= IDX_W'(cfg_pre)));

  // R8: completion holds until a new start
  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R9: refused start flags an error and does not arm
  a_r9_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cfg_as_start) |=> cfg_err);
  a_r9_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cfg_as_start && !armed) |=> !armed);
endmodule

bind rtrig_unit rtrig_unit_chk #(.CW(CW), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .cfg_as_start (cfg_as_start),
  .cfg_pre      (cfg_pre),
  .trig_pulse   (trig_pulse),
  .trig_idx     (trig_idx),
  .armed        (armed),
  .done         (done),
  .cfg_err      (cfg_err)
);

// File: tb/test_rtrig_unit.sv
module test_rtrig_unit;
  localparam int NCH = 4, W = 12, CW = 8, IDX_W = 12, SEL_W = 2;

  logic             clk, rst_n, smp_valid, cfg_slope, cfg_as_start, start;
  logic [NCH*W-1:0] smp_bus;
  logic [SEL_W-1:0] chan_sel;
  logic [1:0]       cfg_mode;
  logic [W-1:0]     cfg_level, cfg_level_hi, cfg_hyst;
  logic [CW-1:0]    cfg_pre, cfg_post;
  logic             trig_pulse, armed, done, cfg_err;
  logic [IDX_W-1:0] trig_idx;

  int checks = 0, errors = 0, cyc = 0;
  int pulse_cnt = 0, last_idx = -1;
  bit cmp_on = 0;
  int stim[$];
  int alt[$];

  // reference model state
  int m_st = 0, m_idx = 0, m_post = 0, m_prev = 0, m_tidx = 0;
  bit m_hasprev = 0, m_primed = 0, m_tp = 0, m_err = 0;

  rtrig_unit #(.NCH(NCH), .W(W), .CW(CW), .IDX_W(IDX_W)) i_rtrig_unit (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_bus(smp_bus),
    .chan_sel(chan_sel), .cfg_mode(cfg_mode), .cfg_slope(cfg_slope),
    .cfg_level(cfg_level), .cfg_level_hi(cfg_level_hi), .cfg_hyst(cfg_hyst),
    .cfg_pre(cfg_pre), .cfg_post(cfg_post), .cfg_as_start(cfg_as_start),
    .start(start), .trig_pulse(trig_pulse), .trig_idx(trig_idx),
    .armed(armed), .done(done), .cfg_err(cfg_err));

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    int x, lvl, hi, hy;
    bit h;
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_idx = 0; m_post = 0; m_prev = 0; m_tidx = 0;
      m_hasprev = 0; m_primed = 0; m_tp = 0; m_err = 0;
    end else begin
      m_tp = 0;
      if (start) begin
        if (cfg_as_start) m_err = 1;
        else begin
          m_err = 0; m_st = (cfg_pre == 0) ? 2 : 1;
          m_idx = 0; m_post = 0; m_hasprev = 0; m_primed = 0; m_prev = 0;
        end
      end else if (smp_valid && m_st >= 1 && m_st <= 3) begin
        x   = int'($signed(smp_bus[int'(chan_sel)*W +: W]));
        lvl = int'($signed(cfg_level));
        hi  = int'($signed(cfg_level_hi));
        hy  = int'(cfg_hyst);
        case (cfg_mode)
          2'd0: h = cfg_slope ? (m_hasprev && m_prev > lvl && x <= lvl)
                              : (m_hasprev && m_prev < lvl && x >= lvl);
          2'd1: h = m_primed && (cfg_slope ? (x <= lvl) : (x >= lvl));
          2'd2: h = (x >= lvl) && (x <= hi);
          default: h = (x < lvl) || (x > hi);
        endcase
        if (m_st == 1) begin
          if (m_idx + 1 == int'(cfg_pre)) m_st = 2;
        end else if (m_st == 2) begin
          if (h) begin
            m_tp = 1; m_tidx = m_idx;
            m_st = (cfg_post == 0) ? 4 : 3;
          end
        end else begin
          m_post++;
          if (m_post == int'(cfg_post)) m_st = 4;
        end
        if (!cfg_slope) begin
          if (x < lvl - hy) m_primed = 1; else if (x >= lvl) m_primed = 0;
        end else begin
          if (x > lvl + hy) m_primed = 1; else if (x <= lvl) m_primed = 0;
        end
        m_prev = x; m_hasprev = 1; m_idx++;
      end
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (cmp_on) begin
      check("R6 pulse", int'(trig_pulse), int'(m_tp));
      check("R6 index", int'(trig_idx), m_tidx);
      check("R2 armed", int'(armed), int'(m_st == 2));
      check("R8 done", int'(done), int'(m_st == 4));
      check("R9 err", int'(cfg_err), int'(m_err));
      if (trig_pulse) begin
        pulse_cnt++;
        last_idx = int'(trig_idx);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic set_cfg(int mode, int slope, int lvl, int hi, int hy, int pre, int post, int ch);
    cfg_mode = mode[1:0]; cfg_slope = slope[0];
    cfg_level = lvl[W-1:0]; cfg_level_hi = hi[W-1:0]; cfg_hyst = hy[W-1:0];
    cfg_pre = pre[CW-1:0]; cfg_post = post[CW-1:0]; chan_sel = ch[SEL_W-1:0];
  endtask

  task automatic pulse_start(bit as_st);
    @(negedge clk);
    cfg_as_start = as_st; start = 1;
    @(negedge clk);
    start = 0; cfg_as_start = 0;
  endtask

  task automatic feed();
    for (int i = 0; i < stim.size(); i++) begin
      for (int c = 0; c < NCH; c++) begin
        int v;
        v = (c == int'(chan_sel)) ? stim[i] : ((i < alt.size()) ? alt[i] : 0);
        smp_bus[c*W +: W] = v[W-1:0];
      end
      smp_valid = 1;
      @(negedge clk);
      smp_valid = 0;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_acq(string req, int exp_idx, int exp_done);
    pulse_cnt = 0; last_idx = -1;
    pulse_start(0);
    feed();
    check({req, " trigger count"}, pulse_cnt, (exp_idx >= 0) ? 1 : 0);
    if (exp_idx >= 0) check({req, " trigger index"}, last_idx, exp_idx);
    check({req, " done"}, int'(done), exp_done);
  endtask

  initial begin
    rst_n = 0; smp_valid = 0; smp_bus = '0; start = 0; cfg_as_start = 0;
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 trig_pulse", int'(trig_pulse), 0);
    check("R1 armed", int'(armed), 0);
    check("R1 done", int'(done), 0);
    check("R1 cfg_err", int'(cfg_err), 0);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);

    // R3 rising, crossing inside pretrigger ignored (R2)
    set_cfg(0, 0, 100, 0, 0, 3, 4, 0);
    stim = '{0, 150, 0, 0, 0, 150, 0, 0, 0, 0}; alt = {};
    run_acq("R3 rising", 5, 1);
    // R3 falling, sample exactly at level counts
    set_cfg(0, 1, 0, 0, 0, 1, 2, 0);
    stim = '{100, 100, 0, 7, 8};
    run_acq("R3 falling", 2, 1);
    // R3 rising onto level, no posttrigger samples (R8)
    set_cfg(0, 0, 0, 0, 0, 0, 0, 3);
    stim = '{-1, 0};
    run_acq("R3 at level", 1, 1);
    // R4 rising hysteresis needs priming below level-hyst
    set_cfg(1, 0, 100, 0, 20, 0, 1, 1);
    stim = '{110, 95, 105, 70, 101, 3};
    run_acq("R4 rising", 4, 1);
    // R4 falling hysteresis
    set_cfg(1, 1, 0, 0, 10, 0, 0, 2);
    stim = '{-20, 5, -3, 15, -1, 0};
    run_acq("R4 falling", 4, 1);
    // R5 inside window
    set_cfg(2, 0, -50, 50, 0, 1, 1, 0);
    stim = '{200, 100, -60, 0, 9};
    run_acq("R5 inside", 3, 1);
    // R5 outside window, limits themselves are inside
    set_cfg(3, 0, -50, 50, 0, 0, 0, 0);
    stim = '{0, 50, -50, 51};
    run_acq("R5 outside", 3, 1);
    // R2 trigger on sample zero when no pretrigger
    set_cfg(2, 0, -50, 50, 0, 0, 0, 0);
    stim = '{0};
    run_acq("R2 zero pre", 0, 1);
    // R2 condition only inside pretrigger: nothing fires, not yet armed
    set_cfg(2, 0, -50, 50, 0, 4, 0, 0);
    stim = '{0, 0, 0};
    run_acq("R2 suppressed", -1, 0);
    check("R2 not armed", int'(armed), 0);
    // R7 repeated crossings give one trigger
    set_cfg(0, 0, 100, 0, 0, 0, 5, 0);
    stim = '{0, 200, 0, 200, 0, 200, 0};
    run_acq("R7 one shot", 1, 1);
    // R10 crossings on other lanes only
    set_cfg(0, 0, 100, 0, 0, 0, 0, 2);
    stim = '{0, 0, 0, 0}; alt = '{0, 200, 0, 200};
    run_acq("R10 other lane", -1, 0);
    set_cfg(0, 0, 100, 0, 0, 0, 0, 1);
    stim = '{0, 200}; alt = '{0, 0};
    run_acq("R10 selected lane", 1, 1);
    // R9 refused start: error flagged, no capture begins
    alt = {};
    set_cfg(2, 0, -50, 50, 0, 0, 0, 0);
    pulse_cnt = 0;
    pulse_start(1);
    check("R9 err set", int'(cfg_err), 1);
    check("R9 not armed", int'(armed), 0);
    stim = '{0, 0};
    feed();
    check("R9 no trigger", pulse_cnt, 0);
    check("R9 done kept", int'(done), 1);
    stim = '{0};
    run_acq("R9 recovery", 0, 1);
    check("R9 err cleared", int'(cfg_err), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule